// File: doc/BRIEF.md
# Dual-Channel DMA Register File

This block is the bus-slave register file of a host network interface that moves data through two DMA channels, one for input and one for output. It decodes a 16-byte window of the peripheral bus into eight 16-bit registers. Each channel has a control/status word, a data buffer, a bus address and a word count. The control/status words, bus addresses and word counts are also driven out continuously to the channel engines.

Writes may be whole words or single bytes. A byte write to a status word or a data buffer replaces only the addressed lane. Writing a status word with its clear bit set also zeroes that channel's bus address and word count. A read of a status word returns the stored bits merged with live conditions from the engines: a forced ready flag and a forced buffer flag. Every access inside the window is acknowledged one cycle after the request, and read data appears in that same cycle. Accesses outside the window get no acknowledge and change nothing.

Top module: `chanreg_bank`

## Requirements
- R1: After a synchronous active-low reset, all eight registers are zero, `busAck` is low and `busRdata` is zero.
- R2: A request whose address bits above bit 3 match those of `BASE` (default octal 767600) is acknowledged on the next cycle. Address bits 3:1 select the register: 0 input status, 1 input data, 2 input address, 3 input count, 4 output status, 5 output data, 6 output address, 7 output count. A request outside the window gets no acknowledge, changes no register and leaves `busRdata` zero.
- R3: A word write (`busByte` low) to a status word or a data buffer replaces all 16 bits.
- R4: A byte write to a status word or a data buffer at an odd address replaces bits 15:8 with `busWdata[15:8]` and keeps bits 7:0. At an even address it replaces bits 7:0 with `busWdata[7:0]` and keeps bits 15:8.
- R5: Any write to a bus address or word count register, word or byte, stores all 16 bits of `busWdata`.
- R6: A status word write whose merged value has bit 1 set stores that merged value, and it zeroes the same channel's bus address and word count. The other channel is unaffected.
- R7: A write to register 7 updates only the output word count. The input word count keeps its value.
- R8: A status word read returns the stored value with two bits ORed in. Bit 8 is set when that channel's done input is high. Bit 7 is set when `ifReady` is high, the channel's done input is high and the stored bit 0 (go) is clear. The input channel uses `inDone` and the output channel uses `outDone`.
- R9: A read of any other register returns its stored value. `busRdata` is zero in every cycle that does not follow an in-window read.
- R10: `inCsr`, `inAddr`, `inCount`, `outCsr`, `outAddr` and `outCount` show the stored registers, and they are updated on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busReq | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busByte | input | 1 | 1 = byte access, lane chosen by address bit 0 |
| busAddr | input | AW (18) | Byte address |
| busWdata | input | 16 | Write data, bytes in their natural lanes |
| busRdata | output | 16 | Read data, registered |
| busAck | output | 1 | Acknowledge, one cycle after an in-window request |
| ifReady | input | 1 | Interface ready from the engines |
| inDone | input | 1 | Input channel done |
| outDone | input | 1 | Output channel done |
| inCsr | output | 16 | Stored input status word |
| inAddr | output | 16 | Input bus address |
| inCount | output | 16 | Input word count |
| outCsr | output | 16 | Stored output status word |
| outAddr | output | 16 | Output bus address |
| outCount | output | 16 | Output word count |

## Verification
A wrong stored register shows on the engine-facing outputs at the edge that took the write. Decode or lane-merge faults therefore appear one cycle after the faulty access. A wrong clear or a misrouted count write also shows in that cycle, on the address or count outputs of the channel involved. Faults in the read path, including the forced ready and buffer flags, appear only in the cycle after a read, so the bench reads each status word under every combination of go, done and interface ready. A behavioural model compares all outputs on every clock.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;
  localparam int REG_COUNT  = 8;
  localparam int IDX_W      = $clog2(REG_COUNT);
  localparam int REGS_PER_CH = 4;
  localparam int CH_COUNT   = REG_COUNT / REGS_PER_CH;
  // register slots within a channel
  localparam int SLOT_CSR  = 0;
  localparam int SLOT_DATA = 1;
  localparam int SLOT_ADDR = 2;
  localparam int SLOT_CNT  = 3;
  // status word bit positions
  localparam int BIT_GO    = 0;
  localparam int BIT_CLEAR = 1;
  localparam int BIT_READY = 7;
  localparam int BIT_BUF   = 8;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrSel;
    logic                 laneHi;
    logic                 laneLo;
    logic                 rdEn;
    logic [IDX_W-1:0]     rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/chanreg_ctrl.sv
module chanreg_ctrl
  import chanreg_pkg::*;
#(
  parameter int AW = 18,
  parameter logic [AW-1:0] BASE = 18'o767600
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic          busByte,
  input  logic [AW-1:0] busAddr,
  output regStrobe_t    strb,
  output logic          busAck
);
  localparam int OFS_BITS = IDX_W + 1;

  logic             hit;
  logic [IDX_W-1:0] regIdx;
  logic             ackQ;

  assign hit    = busReq && (busAddr[AW-1:OFS_BITS] == BASE[AW-1:OFS_BITS]);
  assign regIdx = busAddr[OFS_BITS-1:1];

  always_comb begin
    strb        = '0;
    strb.laneHi = !busByte || busAddr[0];
    strb.laneLo = !busByte || !busAddr[0];
    strb.rdIdx  = regIdx;
    strb.rdEn   = hit && !busWrite;
    if (hit && busWrite) strb.wrSel[regIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= hit;
  end

  assign busAck = ackQ;
endmodule

// File: rtl/chanreg_data.sv
module chanreg_data
  import chanreg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strb,
  input  logic [DW-1:0]                 busWdata,
  input  logic                          ifReady,
  input  logic [CH_COUNT-1:0]           chDone,
  output logic [CH_COUNT-1:0][DW-1:0]   csrQ,
  output logic [CH_COUNT-1:0][DW-1:0]   addrQ,
  output logic [CH_COUNT-1:0][DW-1:0]   cntQ,
  output logic [DW-1:0]                 busRdata
);
  localparam int HALF = DW / 2;

  logic [CH_COUNT-1:0][DW-1:0]  dataQ;
  logic [REG_COUNT-1:0][DW-1:0] readView;
  logic [DW-1:0]                rdataQ;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    localparam int B = ch * REGS_PER_CH;
    logic [DW-1:0] csrNew, dataNew, csrShown;

    assign csrNew  = {strb.laneHi ? busWdata[DW-1:HALF] : csrQ[ch][DW-1:HALF],
                      strb.laneLo ? busWdata[HALF-1:0]  : csrQ[ch][HALF-1:0]};
    assign dataNew = {strb.laneHi ? busWdata[DW-1:HALF] : dataQ[ch][DW-1:HALF],
                      strb.laneLo ? busWdata[HALF-1:0]  : dataQ[ch][HALF-1:0]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        csrQ[ch]  <= '0;
        dataQ[ch] <= '0;
        addrQ[ch] <= '0;
        cntQ[ch]  <= '0;
      end else begin
        if (strb.wrSel[B+SLOT_CSR])  csrQ[ch]  <= csrNew;
        if (strb.wrSel[B+SLOT_DATA]) dataQ[ch] <= dataNew;
        if (strb.wrSel[B+SLOT_CSR] && csrNew[BIT_CLEAR]) begin
          addrQ[ch] <= '0;
          cntQ[ch]  <= '0;
        end else begin
          if (strb.wrSel[B+SLOT_ADDR]) addrQ[ch] <= busWdata;
          if (strb.wrSel[B+SLOT_CNT])  cntQ[ch]  <= busWdata;
        end
      end
    end

    always_comb begin
      csrShown = csrQ[ch];
      if (chDone[ch]) csrShown[BIT_BUF] = 1'b1;
      if (ifReady && chDone[ch] && !csrQ[ch][BIT_GO]) csrShown[BIT_READY] = 1'b1;
    end

    assign readView[B+SLOT_CSR]  = csrShown;
    assign readView[B+SLOT_DATA] = dataQ[ch];
    assign readView[B+SLOT_ADDR] = addrQ[ch];
    assign readView[B+SLOT_CNT]  = cntQ[ch];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= readView[strb.rdIdx];
    else                rdataQ <= '0;
  end

  assign busRdata = rdataQ;
endmodule

// File: rtl/chanreg_bank.sv
module chanreg_bank
  import chanreg_pkg::*;
#(
  parameter int AW = 18,
  parameter logic [AW-1:0] BASE = 18'o767600
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic          busByte,
  input  logic [AW-1:0] busAddr,
  input  logic [15:0]   busWdata,
  output logic [15:0]   busRdata,
  output logic          busAck,
  input  logic          ifReady,
  input  logic          inDone,
  input  logic          outDone,
  output logic [15:0]   inCsr,
  output logic [15:0]   inAddr,
  output logic [15:0]   inCount,
  output logic [15:0]   outCsr,
  output logic [15:0]   outAddr,
  output logic [15:0]   outCount
);
  regStrobe_t                  strb;
  logic [CH_COUNT-1:0][15:0]   csrQ, addrQ, cntQ;

  chanreg_ctrl #(.AW(AW), .BASE(BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busByte(busByte), .busAddr(busAddr), .strb(strb), .busAck(busAck)
  );

  chanreg_data #(.DW(16)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .ifReady(ifReady), .chDone({outDone, inDone}),
    .csrQ(csrQ), .addrQ(addrQ), .cntQ(cntQ), .busRdata(busRdata)
  );

  assign inCsr    = csrQ[0];
  assign inAddr   = addrQ[0];
  assign inCount  = cntQ[0];
  assign outCsr   = csrQ[1];
  assign outAddr  = addrQ[1];
  assign outCount = cntQ[1];
endmodule

// File: rtl/chanreg_bank_chk.sv
module chanreg_bank_chk #(
  parameter int AW = 18,
  parameter logic [AW-1:0] BASE = 18'o767600
) (
  input logic          clk,
  input logic          rstN,
  input logic          busReq,
  input logic          busWrite,
  input logic          busByte,
  input logic [AW-1:0] busAddr,
  input logic [15:0]   busWdata,
  input logic [15:0]   busRdata,
  input logic          busAck,
  input logic          outDone,
  input logic [15:0]   inCsr,
  input logic [15:0]   inAddr,
  input logic [15:0]   inCount,
  input logic [15:0]   outCsr,
  input logic [15:0]   outAddr,
  input logic [15:0]   outCount
);
  logic inWin;
  assign inWin = busReq && (busAddr[AW-1:4] == BASE[AW-1:4]);

  p_ack_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> busAck);
  p_ack_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> !busAck);
  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !inWin) |=> ($stable(inCsr) && $stable(outCsr) && $stable(inAddr)
                            && $stable(outAddr) && $stable(inCount) && $stable(outCount)
                            && busRdata == 16'h0));
  p_byte_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busWrite && busByte && busAddr[3:0] == 4'h1)
      |=> (inCsr[7:0] == $past(inCsr[7:0]) && inCsr[15:8] == $past(busWdata[15:8])));
  p_addr_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busWrite && busAddr[3:1] == 3'd2) |=> inAddr == $past(busWdata));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busWrite && !busByte && busAddr[3:1] == 3'd0 && busWdata[1])
      |=> (inAddr == 16'h0 && inCount == 16'h0 && $stable(outAddr) && $stable(outCount)));
  p_outcnt_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && busWrite && busAddr[3:1] == 3'd7)
      |=> ($stable(inCount) && outCount == $past(busWdata)));
  p_go_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && !busWrite && busAddr[3:1] == 3'd4 && outCsr[0])
      |=> (busRdata[7] == $past(outCsr[7]) && busRdata[8] == ($past(outCsr[8]) || $past(outDone))));
endmodule

bind chanreg_bank chanreg_bank_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busByte(busByte),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
  .outDone(outDone), .inCsr(inCsr), .inAddr(inAddr), .inCount(inCount),
  .outCsr(outCsr), .outAddr(outAddr), .outCount(outCount)
);

// File: tb/test_chanreg_bank.sv
module test_chanreg_bank;
  localparam int AW = 18;
  localparam logic [AW-1:0] BASE = 18'o767600;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busReq = 1'b0, busWrite = 1'b0, busByte = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0]   busWdata = '0;
  logic [15:0]   busRdata;
  logic          busAck;
  logic          ifReady = 1'b0, inDone = 1'b0, outDone = 1'b0;
  logic [15:0]   inCsr, inAddr, inCount, outCsr, outAddr, outCount;

  int checkCount = 0;
  int failCount  = 0;
  int cycles     = 0;
  bit started    = 0;

  always #4 clk = ~clk;

  chanreg_bank #(.AW(AW), .BASE(BASE)) i_chanreg_bank (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busByte(busByte),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .ifReady(ifReady), .inDone(inDone), .outDone(outDone),
    .inCsr(inCsr), .inAddr(inAddr), .inCount(inCount),
    .outCsr(outCsr), .outAddr(outAddr), .outCount(outCount)
  );

  // behavioural reference model
  logic [15:0] mReg [8];
  logic        expAck;
  logic [15:0] expRd;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mReg[i] = 16'h0;
      expAck = 1'b0;
      expRd  = 16'h0;
    end else begin
      int idx;
      logic [15:0] v;
      bit win;
      win    = busReq && ((busAddr >> 4) == (BASE >> 4));
      idx    = int'(busAddr[3:1]);
      expAck = win;
      expRd  = 16'h0;
      if (win && busWrite) begin
        if (idx == 2 || idx == 3 || idx == 6 || idx == 7) begin
          mReg[idx] = busWdata;
        end else begin
          if (!busByte)        v = busWdata;
          else if (busAddr[0]) v = {busWdata[15:8], mReg[idx][7:0]};
          else                 v = {mReg[idx][15:8], busWdata[7:0]};
          if ((idx == 0 || idx == 4) && v[1]) begin
            mReg[idx+2] = 16'h0;
            mReg[idx+3] = 16'h0;
          end
          mReg[idx] = v;
        end
      end else if (win) begin
        v = mReg[idx];
        if (idx == 0 || idx == 4) begin
          bit dn;
          dn = (idx == 0) ? inDone : outDone;
          if (dn) v = v | 16'h0100;
          if (dn && ifReady && !v[0]) v = v | 16'h0080;
        end
        expRd = v;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h at time %0t", tag, got, exp, $time);
    end
  endtask

  // compare every cycle
  always @(negedge clk) begin
    if (started) begin
      chk("R2 busAck",          {15'h0, busAck}, {15'h0, expAck});
      chk("R8/R9 busRdata",     busRdata, expRd);
      chk("R3/R4/R6/R10 inCsr", inCsr,    mReg[0]);
      chk("R5/R6/R10 inAddr",   inAddr,   mReg[2]);
      chk("R5/R7 inCount",      inCount,  mReg[3]);
      chk("R3/R6 outCsr",       outCsr,   mReg[4]);
      chk("R5/R6 outAddr",      outAddr,  mReg[6]);
      chk("R7 outCount",        outCount, mReg[7]);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  task automatic access(input bit w, input bit b, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    busReq = 1'b1; busWrite = w; busByte = b; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0; busByte = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 inCsr after reset", inCsr, 16'h0);
    chk("R1 outCount after reset", outCount, 16'h0);
    chk("R1 rdata after reset", busRdata, 16'h0);
    chk("R1 ack after reset", {15'h0, busAck}, 16'h0);

    access(1, 0, BASE + 0, 16'h0035);
    chk("R3 word write input status", inCsr, 16'h0035);
    chk("R10 engine view", inCsr, 16'h0035);
    ifReady = 1; inDone = 1;
    access(0, 0, BASE + 0, 16'h0);
    chk("R8 go set blocks ready", busRdata, 16'h0135);
    access(1, 0, BASE + 0, 16'h0034);
    access(0, 0, BASE + 0, 16'h0);
    chk("R8 ready forced", busRdata, 16'h01B4);
    access(1, 1, BASE + 1, 16'hA5FF);
    chk("R4 odd byte status", inCsr, 16'hA534);
    access(1, 0, BASE + 2, 16'h1111);
    access(1, 1, BASE + 2, 16'hFF77);
    access(0, 0, BASE + 2, 16'h0);
    chk("R4 even byte data", busRdata, 16'h1177);
    chk("R9 data read", busRdata, 16'h1177);
    @(negedge clk);
    chk("R9 rdata zero when idle", busRdata, 16'h0);
    access(1, 1, BASE + 4, 16'hBEEF);
    chk("R5 byte write full address", inAddr, 16'hBEEF);
    access(1, 0, BASE + 6, 16'hCAFE);
    access(1, 0, BASE + 14, 16'h0042);
    chk("R7 output count", outCount, 16'h0042);
    chk("R7 input count kept", inCount, 16'hCAFE);
    access(1, 0, BASE + 12, 16'h7777);
    access(1, 0, BASE + 8, 16'h0006);
    chk("R6 out status stored", outCsr, 16'h0006);
    chk("R6 out address cleared", outAddr, 16'h0);
    chk("R6 out count cleared", outCount, 16'h0);
    chk("R6 input address untouched", inAddr, 16'hBEEF);
    access(1, 1, BASE + 0, 16'h0002);
    chk("R6 byte clear status", inCsr, 16'hA502);
    chk("R6 byte clear address", inAddr, 16'h0);
    chk("R6 byte clear count", inCount, 16'h0);
    access(1, 0, BASE + 16, 16'hFFFF);
    chk("R2 miss no ack", {15'h0, busAck}, 16'h0);
    chk("R2 miss no change", outCsr, 16'h0006);
    access(1, 0, BASE - 2, 16'hFFFF);
    chk("R2 miss below window", inCount, 16'h0);
    access(0, 0, BASE + 16, 16'h0);
    chk("R2 miss read zero", busRdata, 16'h0);
    ifReady = 0; outDone = 1;
    access(0, 0, BASE + 8, 16'h0);
    chk("R8 output buffer flag", busRdata, 16'h0106);
    ifReady = 1;
    access(0, 0, BASE + 8, 16'h0);
    chk("R8 output ready forced", busRdata, 16'h0186);

    for (int n = 0; n < 400; n++) begin
      int ofs;
      ofs = $urandom_range(0, 19) - 2;
      ifReady = 1'($urandom);
      inDone  = 1'($urandom);
      outDone = 1'($urandom);
      access(1'($urandom), 1'($urandom), BASE + AW'(ofs), 16'($urandom));
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule